// File: doc/BRIEF.md
# Trigger-Gated Multi-Event Hit Buffer

This block sits between a group of pixel readout chips and the off-detector readout path. Each clock it takes one binary hit word: one bit per pixel, for all chips side by side. It keeps every word in a fixed-latency circular delay line while the first-level trigger decision is still pending. A first-level accept copies the hit word that is now leaving the delay line into one of four event slots. A first-level reject leaves the slots untouched.

An occupied slot waits for its second-level decision. These decisions are applied in arrival order, always to the oldest slot that has not yet been decided. An accept queues the slot for readout. A reject marks it for discard. Readout is a valid/ready stream of one chip word per transfer, with chip 0 first. The slot is released only when the last word has been taken.

A busy flag is raised while all four slots are occupied. It tells the trigger source to stop sending first-level accepts. An accept that still arrives while busy is dropped and reported on an overflow pulse.

Top module: `hit_event_buffer`

## Requirements
- R1: A first-level decision sampled at clock edge n acts on the hit word sampled at edge n-LAT. Words sampled before the first LAT edges after reset read as all zero.
- R2: An accepted event is streamed as NCHIP words. Word k carries bits [k*CHIP_W +: CHIP_W] of the stored hit word, and rd_last is high only on word NCHIP-1.
- R3: busy is high exactly while four slots are occupied. It rises in the cycle after the edge that stores the fourth event.
- R4: A first-level accept sampled while busy is high produces a one-cycle l1_overflow pulse after that edge, and it stores nothing.
- R5: A first-level decision with l1_accept low changes neither busy nor the readout stream.
- R6: Second-level decisions are applied in order, each to the oldest occupied slot that is still undecided.
- R7: A second-level reject discards its event, and no words of it are streamed. When it is the oldest occupied slot, the slot is free (busy low) one edge after the decision edge.
- R8: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data holds its value.
- R9: A second-level decision that arrives while no slot is awaiting one is ignored.
- R10: After reset busy, l1_overflow and rd_valid are low.
- R11: Second-level accepted events are streamed in the order in which they were stored, with no gap inside an event while rd_ready is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_in | input | NCHIP*CHIP_W | Hit bits of all chips, chip k in bits [k*CHIP_W +: CHIP_W] |
| l1_valid | input | 1 | First-level decision present this cycle |
| l1_accept | input | 1 | First-level decision value, 1 = accept |
| l2_valid | input | 1 | Second-level decision present this cycle |
| l2_accept | input | 1 | Second-level decision value, 1 = accept |
| busy | output | 1 | All event slots occupied |
| l1_overflow | output | 1 | Pulse: a first-level accept arrived while busy and was dropped |
| rd_valid | output | 1 | Readout word available |
| rd_ready | input | 1 | Readout sink takes the word |
| rd_data | output | CHIP_W | Current chip word of the event being streamed |
| rd_last | output | 1 | Current word is the last chip of its event |

## Verification
The captured word is due from the decision edge itself: the hit word that was presented LAT edges earlier. The bench drives hit_in as a known function of its own edge counter, so it can compute that word directly. busy and rd_valid change in the cycle after the edge of the accept or decision that affects them. A discarded oldest slot frees one edge later, and l1_overflow is high for exactly the cycle after the offending edge. All inputs change on the falling edge, and all outputs are sampled on the falling edge, half a period after the rising edge whose effect is being checked.

// File: rtl/hit_event_buffer.sv
module hit_event_buffer #(
  parameter int NCHIP  = 10,
  parameter int CHIP_W = 16,
  parameter int LAT    = 8,
  parameter int NSLOT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCHIP*CHIP_W-1:0] hit_in,
  input  logic                    l1_valid,
  input  logic                    l1_accept,
  input  logic                    l2_valid,
  input  logic                    l2_accept,
  output logic                    busy,
  output logic                    l1_overflow,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [CHIP_W-1:0]       rd_data,
  output logic                    rd_last
);
  localparam int HW = NCHIP * CHIP_W;
  localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int PW = SW + 1;
  localparam int CW = (NCHIP > 1) ? $clog2(NCHIP) : 1;

  localparam logic [1:0] S_FREE = 2'd0;
  localparam logic [1:0] S_WAIT = 2'd1;
  localparam logic [1:0] S_READ = 2'd2;
  localparam logic [1:0] S_DROP = 2'd3;

  logic [HW-1:0] dline [LAT];
  logic [LW-1:0] dptr;
  logic [HW-1:0] delayed;

  logic [HW-1:0] slot  [NSLOT];
  logic [1:0]    state [NSLOT];
  logic [PW-1:0] head, l2p, rdp, occ;
  logic [CW-1:0] widx;
  logic [SW-1:0] hi, li, ri;
  logic          alloc, decide, take, skip;

  assign delayed = dline[dptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr <= '0;
      for (int i = 0; i < LAT; i++) dline[i] <= '0;
    end else begin
      dline[dptr] <= hit_in;
      dptr <= (dptr == LW'(LAT - 1)) ? '0 : dptr + 1'b1;
    end
  end

  assign hi  = head[SW-1:0];
  assign li  = l2p[SW-1:0];
  assign ri  = rdp[SW-1:0];
  assign occ = head - rdp;

  assign busy     = (occ == PW'(NSLOT));
  assign alloc    = l1_valid && l1_accept && !busy;
  assign decide   = l2_valid && (l2p != head);
  assign rd_valid = (occ != '0) && (state[ri] == S_READ);
  assign skip     = (occ != '0) && (state[ri] == S_DROP);
  assign take     = rd_valid && rd_ready;
  assign rd_data  = slot[ri][int'(widx)*CHIP_W +: CHIP_W];
  assign rd_last  = (widx == CW'(NCHIP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head        <= '0;
      l2p         <= '0;
      rdp         <= '0;
      widx        <= '0;
      l1_overflow <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        state[i] <= S_FREE;
        slot[i]  <= '0;
      end
    end else begin
      l1_overflow <= l1_valid && l1_accept && busy;
      if (alloc) begin
        slot[hi]  <= delayed;
        state[hi] <= S_WAIT;
        head      <= head + 1'b1;
      end
      if (decide) begin
        state[li] <= l2_accept ? S_READ : S_DROP;
        l2p       <= l2p + 1'b1;
      end
      if (skip) begin
        state[ri] <= S_FREE;
        rdp       <= rdp + 1'b1;
      end else if (take) begin
        if (rd_last) begin
          state[ri] <= S_FREE;
          rdp       <= rdp + 1'b1;
          widx      <= '0;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  a_r3_never_overfilled: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(NSLOT));

  a_r4_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_valid && l1_accept && busy) |=> l1_overflow);

  a_r4_overflow_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_valid && busy) |=> (head == $past(head)));

  a_r5_reject_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_valid && !l1_accept) |=> (head == $past(head)));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r9_idle_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_valid && (l2p == head)) |=> (l2p == $past(l2p)));

  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !rd_last) |=> rd_valid);

endmodule

// File: tb/tb_hit_event_buffer.sv
module tb_hit_event_buffer;
  localparam int NCHIP  = 10;
  localparam int CHIP_W = 16;
  localparam int LAT    = 8;
  localparam int HW     = NCHIP * CHIP_W;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [HW-1:0]     hit_in;
  logic              l1_valid = 0, l1_accept = 0, l2_valid = 0, l2_accept = 0;
  logic              busy, l1_overflow, rd_valid, rd_last;
  logic              rd_ready = 0;
  logic [CHIP_W-1:0] rd_data;

  int edge_n = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  function automatic logic [HW-1:0] pat(int n);
    logic [HW-1:0] w;
    for (int c = 0; c < NCHIP; c++)
      w[c*CHIP_W +: CHIP_W] = CHIP_W'(n * 16 + c) ^ 16'hA500;
    return w;
  endfunction

  assign hit_in = pat(edge_n);

  hit_event_buffer #(.NCHIP(NCHIP), .CHIP_W(CHIP_W), .LAT(LAT), .NSLOT(4)) dut (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in),
    .l1_valid(l1_valid), .l1_accept(l1_accept),
    .l2_valid(l2_valid), .l2_accept(l2_accept),
    .busy(busy), .l1_overflow(l1_overflow),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic l1(logic acc, output int n);
    l1_valid = 1; l1_accept = acc; n = edge_n;
    @(negedge clk);
    l1_valid = 0; l1_accept = 0;
  endtask

  task automatic l2(logic acc);
    l2_valid = 1; l2_accept = acc;
    @(negedge clk);
    l2_valid = 0; l2_accept = 0;
  endtask

  task automatic read_event(int n, string req, int stall_at);
    logic [HW-1:0] exp_w;
    exp_w = pat(n - LAT);
    rd_ready = 1;
    for (int c = 0; c < NCHIP; c++) begin
      check({req, " valid"}, 32'(rd_valid), 32'd1);
      check({req, " data"}, 32'(rd_data), 32'(exp_w[c*CHIP_W +: CHIP_W]));
      check({req, " last"}, 32'(rd_last), 32'(c == NCHIP - 1));
      if (c == stall_at) begin
        rd_ready = 0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check("R8 stall valid", 32'(rd_valid), 32'd1);
          check("R8 stall data", 32'(rd_data), 32'(exp_w[c*CHIP_W +: CHIP_W]));
        end
        rd_ready = 1;
      end
      @(negedge clk);
    end
    rd_ready = 0;
  endtask

  task automatic t_reset;
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 overflow", 32'(l1_overflow), 32'd0);
    check("R10 rd_valid", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_single;
    int n;
    l1(1'b1, n);
    check("R3 busy after one", 32'(busy), 32'd0);
    check("R6 no readout before L2", 32'(rd_valid), 32'd0);
    l2(1'b1);
    read_event(n, "R1 R2", -1);
    check("R2 stream ended", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_reject_and_idle;
    int n;
    l1(1'b0, n);
    idle(2);
    check("R5 busy", 32'(busy), 32'd0);
    check("R5 rd_valid", 32'(rd_valid), 32'd0);
    l2(1'b1);
    idle(2);
    check("R9 ignored L2", 32'(rd_valid), 32'd0);
    t_single();
  endtask

  task automatic t_fill;
    int n0, n1, n2, n3, nx;
    l1(1'b1, n0); idle(1);
    l1(1'b1, n1); idle(2);
    l1(1'b1, n2);
    check("R3 busy at three", 32'(busy), 32'd0);
    l1(1'b1, n3);
    check("R3 busy at four", 32'(busy), 32'd1);
    check("R4 no overflow yet", 32'(l1_overflow), 32'd0);
    l1(1'b1, nx);
    check("R4 overflow pulse", 32'(l1_overflow), 32'd1);
    idle(1);
    check("R4 overflow one cycle", 32'(l1_overflow), 32'd0);
    check("R4 still busy", 32'(busy), 32'd1);
    l2(1'b0);
    idle(1);
    check("R7 oldest freed", 32'(busy), 32'd0);
    check("R7 nothing streamed", 32'(rd_valid), 32'd0);
    l2(1'b1);
    l2(1'b0);
    l2(1'b1);
    read_event(n1, "R6 R11 second", 2);
    idle(1);
    read_event(n3, "R6 R11 fourth", -1);
    idle(2);
    check("R7 R11 no dropped words", 32'(rd_valid), 32'd0);
    check("R4 dropped accept absent", 32'(busy), 32'd0);
    if (n0 < 0 || nx < 0) check("R4 bookkeeping", 32'd0, 32'd1);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(LAT + 4);
    t_single();
    idle(3);
    t_reject_and_idle();
    idle(3);
    t_fill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule